// File: doc/BRIEF.md
# Watchdog Configuration Lock Controller

This block holds the configuration registers of a watchdog timer: a control word, a timeout period and a service window. It also decides which register writes are accepted. Two lock levels protect the three registers. The first is a hard lock that stays set until reset. The second is a soft lock that software can release with a two-word key written to the service address.

While either lock is active, writes to the three registers are dropped, and reads still return the stored values. The service address keeps no data. Each write to it is a key, and a small detector inspects the keys for the release pair. The detector ignores the two watchdog-refresh keys. It runs whether or not the watchdog is enabled.

The register values drive the counting logic outside this block through the `ctrlVal`, `timeoutVal` and `windowVal` outputs. The lock state is shown on two status pins.

Top module: `cfgLock`

## Requirements
- R1: While `rstN` is low, and after it rises, the registers hold these values. Control is 0, except that bit 0 equals the `EN_AT_RESET` parameter (default 0). Timeout holds `TO_RST` (default 0x100). Window holds `WN_RST` (default 0). Both lock outputs are 0.
- R2: Address map: 0 is control, 1 is timeout, 2 is window, 3 is service. With no lock set, a write to address 0, 1 or 2 stores `wrData` (control keeps its low `CTRL_W` bits). `rdData` shows the new value in the cycle after the write edge. A read of address 3 returns 0.
- R3: Control bit 0 is the watchdog enable, bit 1 is the soft lock and bit 2 is the hard lock. A control write that sets a lock bit is itself stored, and the lock holds from the next write onward.
- R4: While the soft lock or the hard lock is set, writes to addresses 0, 1 and 2 change nothing. Reads keep returning the held values.
- R5: Once set, the hard lock stays set until reset. Nothing else clears it.
- R6: A service write whose low 16 bits are 0xC520, followed later by one whose low 16 bits are 0xD928, clears the soft lock. Any number of idle cycles may pass between the two writes. No other control bit changes.
- R7: Service writes of 0xA602 or 0xB480 that come between 0xC520 and 0xD928 do not disturb the pending release.
- R8: Any other service value between 0xC520 and 0xD928 cancels the pending release. A fresh 0xC520 re-arms the detector at any time, whatever was written before it.
- R9: After a completed release, the detector is idle again. A 0xD928 with no 0xC520 before it has no effect.
- R10: The release works while the enable bit is clear. The release never clears the hard lock, so with the hard lock set, writes stay blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the current address |
| addr | input | 2 | Register address for writes and reads |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Value of the register at `addr` |
| ctrlVal | output | CTRL_W | Current control word |
| timeoutVal | output | DATA_W | Current timeout period |
| windowVal | output | DATA_W | Current window value |
| softLocked | output | 1 | Soft lock active |
| hardLocked | output | 1 | Hard lock active |

## Verification
The assertions assume that `wrEn`, `addr` and `wrData` hold known values at every rising edge. They also assume that a cycle carries at most one write, so a control write and a key write never reach the registers together. The bench meets both conditions: it drives every input on the falling edge, holds each write for exactly one cycle, and keeps `wrEn` low between writes. Reset is applied at the start of each scenario, so the sticky hard lock never carries over from one scenario to the next.

// File: rtl/cfgLockPkg.sv
package cfgLockPkg;
  localparam int KEY_W = 16;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_TO   = 2'd1;
  localparam logic [1:0] ADDR_WN   = 2'd2;
  localparam logic [1:0] ADDR_SVC  = 2'd3;

  localparam int BIT_EN   = 0;
  localparam int BIT_SOFT = 1;
  localparam int BIT_HARD = 2;

  localparam logic [KEY_W-1:0] KEY_REL1 = 16'hC520;
  localparam logic [KEY_W-1:0] KEY_REL2 = 16'hD928;
  localparam logic [KEY_W-1:0] KEY_SVC1 = 16'hA602;
  localparam logic [KEY_W-1:0] KEY_SVC2 = 16'hB480;

  typedef enum logic {KEY_IDLE, KEY_ARMED} keyState_t;

  typedef struct packed {
    logic ldCtrl;
    logic ldTimeout;
    logic ldWindow;
    logic release_;
  } strobe_t;
endpackage

// File: rtl/cfgLockCtrl.sv
module cfgLockCtrl
  import cfgLockPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              softLocked,
  input  logic              hardLocked,
  output strobe_t           strobe
);
  keyState_t keyQ, keyD;
  logic locked;
  logic svcWrite;
  logic [KEY_W-1:0] key;
  logic isSvcKey;

  assign locked   = softLocked | hardLocked;
  assign svcWrite = wrEn && (addr == ADDR_SVC);
  assign key      = wrData[KEY_W-1:0];
  assign isSvcKey = (key == KEY_SVC1) || (key == KEY_SVC2);

  always_comb begin
    strobe.ldCtrl    = wrEn && (addr == ADDR_CTRL) && !locked;
    strobe.ldTimeout = wrEn && (addr == ADDR_TO) && !locked;
    strobe.ldWindow  = wrEn && (addr == ADDR_WN) && !locked;
    strobe.release_  = svcWrite && (keyQ == KEY_ARMED) && (key == KEY_REL2);
  end

  // Key detector: refresh keys pass through, any other value disarms.
  always_comb begin
    keyD = keyQ;
    if (svcWrite) begin
      if (key == KEY_REL1)      keyD = KEY_ARMED;
      else if (isSvcKey)        keyD = keyQ;
      else                      keyD = KEY_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyQ <= KEY_IDLE;
    else       keyQ <= keyD;
  end
endmodule

// File: rtl/cfgLockData.sv
module cfgLockData
  import cfgLockPkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          CTRL_W      = 8,
  parameter logic [31:0] TO_RST      = 32'h100,
  parameter logic [31:0] WN_RST      = 32'h0,
  parameter bit          EN_AT_RESET = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CTRL_W-1:0] ctrlVal,
  output logic [DATA_W-1:0] timeoutVal,
  output logic [DATA_W-1:0] windowVal,
  output logic              softLocked,
  output logic              hardLocked
);
  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(EN_AT_RESET);

  logic [CTRL_W-1:0] ctrlQ;
  logic [DATA_W-1:0] toQ, wnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= CTRL_RST;
    end else if (strobe.ldCtrl) begin
      ctrlQ <= wrData[CTRL_W-1:0];
      ctrlQ[BIT_HARD] <= ctrlQ[BIT_HARD] | wrData[BIT_HARD];
    end else if (strobe.release_) begin
      ctrlQ[BIT_SOFT] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toQ <= DATA_W'(TO_RST);
      wnQ <= DATA_W'(WN_RST);
    end else begin
      if (strobe.ldTimeout) toQ <= wrData;
      if (strobe.ldWindow)  wnQ <= wrData;
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_CTRL: rdData = DATA_W'(ctrlQ);
      ADDR_TO:   rdData = toQ;
      ADDR_WN:   rdData = wnQ;
      default:   rdData = '0;
    endcase
  end

  assign ctrlVal    = ctrlQ;
  assign timeoutVal = toQ;
  assign windowVal  = wnQ;
  assign softLocked = ctrlQ[BIT_SOFT];
  assign hardLocked = ctrlQ[BIT_HARD];
endmodule

// File: rtl/cfgLock.sv
module cfgLock
  import cfgLockPkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          CTRL_W      = 8,
  parameter logic [31:0] TO_RST      = 32'h100,
  parameter logic [31:0] WN_RST      = 32'h0,
  parameter bit          EN_AT_RESET = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CTRL_W-1:0] ctrlVal,
  output logic [DATA_W-1:0] timeoutVal,
  output logic [DATA_W-1:0] windowVal,
  output logic              softLocked,
  output logic              hardLocked
);
  strobe_t strobe;

  cfgLockCtrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .softLocked(softLocked), .hardLocked(hardLocked), .strobe(strobe)
  );

  cfgLockData #(
    .DATA_W(DATA_W), .CTRL_W(CTRL_W), .TO_RST(TO_RST),
    .WN_RST(WN_RST), .EN_AT_RESET(EN_AT_RESET)
  ) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr), .wrData(wrData),
    .rdData(rdData), .ctrlVal(ctrlVal), .timeoutVal(timeoutVal),
    .windowVal(windowVal), .softLocked(softLocked), .hardLocked(hardLocked)
  );
endmodule

// File: rtl/cfgLockChk.sv
module cfgLockChk #(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wrData,
  input logic [CTRL_W-1:0] ctrlVal,
  input logic [DATA_W-1:0] timeoutVal,
  input logic [DATA_W-1:0] windowVal,
  input logic              softLocked,
  input logic              hardLocked
);
  localparam logic [CTRL_W-1:0] NO_SOFT = ~(CTRL_W'(2));

  AST_HARD_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    hardLocked |=> hardLocked); // R5
  AST_TIMEOUT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (softLocked || hardLocked) |=> $stable(timeoutVal)); // R4
  AST_WINDOW_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (softLocked || hardLocked) |=> $stable(windowVal)); // R4
  AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (softLocked || hardLocked) |=> $stable(ctrlVal & NO_SOFT)); // R4
  AST_SOFT_FALL_KEY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(softLocked) |-> $past(wrEn && addr == 2'd3 && wrData[15:0] == 16'hD928)); // R6
  AST_SOFT_RISE_UNLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(softLocked) |-> $past(wrEn && addr == 2'd0 && !softLocked && !hardLocked)); // R3
  AST_HARD_RISE_UNLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hardLocked) |-> $past(wrEn && addr == 2'd0 && !softLocked && !hardLocked)); // R3
endmodule

bind cfgLock cfgLockChk #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .ctrlVal(ctrlVal), .timeoutVal(timeoutVal), .windowVal(windowVal),
  .softLocked(softLocked), .hardLocked(hardLocked)
);

// File: tb/cfgLock_tb_top.sv
module cfgLock_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, timeoutVal, windowVal;
  logic [7:0] ctrlVal;
  logic softLocked, hardLocked;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  cfgLock dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .ctrlVal(ctrlVal), .timeoutVal(timeoutVal),
    .windowVal(windowVal), .softLocked(softLocked), .hardLocked(hardLocked)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    wrEn = 1'b0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic tResetState();
    logic [31:0] v;
    doReset();
    rd(2'd0, v); check("R1 ctrl", v, 32'h0);
    rd(2'd1, v); check("R1 timeout", v, 32'h100);
    rd(2'd2, v); check("R1 window", v, 32'h0);
    check("R1 locks", {softLocked, hardLocked}, 32'h0);
  endtask

  task automatic tUnlockedWrites();
    logic [31:0] v;
    doReset();
    wr(2'd1, 32'hDEAD_BEEF);
    wr(2'd2, 32'h0000_0400);
    wr(2'd0, 32'h0000_0091);
    rd(2'd1, v); check("R2 timeout", v, 32'hDEAD_BEEF);
    rd(2'd2, v); check("R2 window", v, 32'h400);
    rd(2'd0, v); check("R2 ctrl", v, 32'h91);
    wr(2'd3, 32'h1234);
    rd(2'd3, v); check("R2 service reads zero", v, 32'h0);
  endtask

  task automatic tSoftLockBlocks();
    logic [31:0] v;
    doReset();
    wr(2'd0, 32'h0000_0013);
    rd(2'd0, v); check("R3 lock write applied", v, 32'h13);
    check("R3 softLocked", softLocked, 1'b1);
    wr(2'd1, 32'h5555);
    wr(2'd2, 32'h6666);
    wr(2'd0, 32'h0000_0000);
    rd(2'd1, v); check("R4 timeout held", v, 32'h100);
    rd(2'd2, v); check("R4 window held", v, 32'h0);
    rd(2'd0, v); check("R4 ctrl held", v, 32'h13);
  endtask

  task automatic tReleaseSequence();
    logic [31:0] v;
    doReset();
    wr(2'd0, 32'h0000_0013);
    wr(2'd3, 32'h0000_C520);
    repeat (20) @(negedge clk);
    check("R6 still locked before second key", softLocked, 1'b1);
    wr(2'd3, 32'h0000_D928);
    check("R6 soft cleared", softLocked, 1'b0);
    rd(2'd0, v); check("R6 other ctrl bits kept", v, 32'h11);
    wr(2'd1, 32'h777);
    rd(2'd1, v); check("R6 write accepted after release", v, 32'h777);
  endtask

  task automatic tRefreshInterleave();
    doReset();
    wr(2'd0, 32'h0000_0002);
    wr(2'd3, 32'h0000_C520);
    wr(2'd3, 32'h0000_A602);
    wr(2'd3, 32'h0000_B480);
    wr(2'd3, 32'h0000_D928);
    check("R7 refresh keys ignored", softLocked, 1'b0);
  endtask

  task automatic tOtherCancels();
    doReset();
    wr(2'd0, 32'h0000_0002);
    wr(2'd3, 32'h0000_C520);
    wr(2'd3, 32'h0000_1111);
    wr(2'd3, 32'h0000_D928);
    check("R8 other value cancels", softLocked, 1'b1);
    wr(2'd3, 32'h0000_D928);
    wr(2'd3, 32'h0000_C520);
    wr(2'd3, 32'h0000_C520);
    wr(2'd3, 32'h0000_D928);
    check("R8 fresh arm after junk", softLocked, 1'b0);
  endtask

  task automatic tLoneSecondKey();
    doReset();
    wr(2'd0, 32'h0000_0002);
    wr(2'd3, 32'h0000_D928);
    check("R9 lone second key", softLocked, 1'b1);
    wr(2'd3, 32'h0000_C520);
    wr(2'd3, 32'h0000_D928);
    check("R9 release", softLocked, 1'b0);
    wr(2'd0, 32'h0000_0002);
    wr(2'd3, 32'h0000_D928);
    check("R9 detector idle after release", softLocked, 1'b1);
  endtask

  task automatic tHardLock();
    logic [31:0] v;
    doReset();
    wr(2'd0, 32'h0000_0006);
    check("R10 both locks set", {softLocked, hardLocked}, 32'h3);
    wr(2'd3, 32'h0000_C520);
    wr(2'd3, 32'h0000_D928);
    check("R10 soft cleared, enable clear", {softLocked, hardLocked}, 32'h1);
    wr(2'd0, 32'h0000_0000);
    wr(2'd1, 32'h0000_0999);
    rd(2'd0, v); check("R5 hard sticky", v, 32'h4);
    rd(2'd1, v); check("R10 still blocked by hard", v, 32'h100);
    doReset();
    check("R5 reset clears hard", hardLocked, 1'b0);
  endtask

  initial begin
    tResetState();
    tUnlockedWrites();
    tSoftLockBlocks();
    tReleaseSequence();
    tRefreshInterleave();
    tOtherCancels();
    tLoneSecondKey();
    tHardLock();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule